// File: doc/BRIEF.md
# Keypad Row-Column Code Converter

This block turns the seven line signals of a twelve-key telephone keypad into a 4-bit key code. The keypad has four row lines and three column lines. Pressing a key drives exactly one row line and one column line high. A combinational stage checks that the lines form a legal single press and maps the row and column position to a code. A register stage then presents that code to synchronous logic, together with a valid flag and a one-cycle pulse for each new key.

The keys are laid out in four rows of three. From top to bottom the rows are 1-2-3, 4-5-6, 7-8-9 and star-0-hash, and the columns run left to right. Bit 0 of `row_in` is the top row and bit 0 of `col_in` is the left column. Any pattern that is not exactly one row plus one column yields the idle code 1111 with valid low. Scanning drive and debouncing of the keypad are handled elsewhere.

Top module: `keypad_code_conv`

## Requirements
- R1: A single press at row r and column c, with r in 1..3 and c in 1..3 (row_in bit r-1, col_in bit c-1), gives code 3*(r-1)+c, so row 2 column 2 gives 0101. Valid is high.
- R2: Row 4 column 2 gives code 0000 (digit zero), with valid high.
- R3: Row 4 column 1 (star) gives 1010 and row 4 column 3 (hash) gives 1011, each with valid high.
- R4: With no row and no column high, the code is 1111 and valid is low.
- R5: With two or more rows high, or two or more columns high, the code is 1111 and valid is low.
- R6: A row high with no column high, or a column high with no row high, is treated as no key: code 1111, valid low.
- R7: The code and valid outputs are registered. Both reflect the lines sampled at the previous rising clock edge.
- R8: A synchronous active-high reset sets the code to 1111 and clears valid and the new-key pulse on the next rising edge.
- R9: The new-key output is high for exactly one cycle, in the same cycle that valid first goes high.
- R10: The new-key output pulses when the code changes while valid stays high. It stays low while the same key is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| row_in | input | ROWS (4) | Row lines, bit 0 = top row |
| col_in | input | COLS (3) | Column lines, bit 0 = left column |
| key_code | output | CODE_W (4) | Registered key code, 1111 when idle |
| key_valid | output | 1 | Registered flag, high for a legal single press |
| key_new | output | 1 | One-cycle pulse for a newly seen key |

## Verification
The code, valid and new-key outputs all come from a single register rank. Each one therefore changes at the first rising edge after the line pattern is applied, and a reset likewise takes effect at its first edge. The bench drives the lines on the falling edge and advances its reference model on the rising edge. It compares all three outputs at the next falling edge, which is exactly one cycle after each stimulus. Held keys, direct key-to-key changes and returns to idle are each run across several cycles, so that pulse width and the absence of pulses are also compared at that one-cycle offset.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_CODE_W = 4;
  localparam logic [KP_CODE_W-1:0] KP_IDLE = 4'b1111;
  localparam logic [KP_CODE_W-1:0] KP_STAR = 4'b1010;
  localparam logic [KP_CODE_W-1:0] KP_HASH = 4'b1011;

  // Map a zero-based row/column position to its key code.
  // Upper rows hold digits 1.. in reading order; the last row is star, 0, hash.
  function automatic logic [KP_CODE_W-1:0] kp_map(input int row, input int col,
                                                   input int rows, input int cols);
    logic [KP_CODE_W-1:0] res;
    if (row < rows - 1) begin
      res = KP_CODE_W'(row * cols + col + 1);
    end else if (col == 0) begin
      res = KP_STAR;
    end else if (col == cols - 1) begin
      res = KP_HASH;
    end else begin
      res = '0;
    end
    return res;
  endfunction
endpackage

// File: rtl/kp_line_check.sv
module kp_line_check #(
  parameter int W  = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  lines,
  output logic          single,
  output logic [IW-1:0] index
);
  logic [W-1:0] below;

  // below[i]: some line with a lower index is high
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_below
      if (g == 0) begin : g_first
        assign below[g] = 1'b0;
      end else begin : g_rest
        assign below[g] = below[g-1] | lines[g-1];
      end
    end
  endgenerate

  always_comb begin
    logic many;
    many  = 1'b0;
    index = '0;
    for (int i = 0; i < W; i++) begin
      if (lines[i] && below[i]) many = 1'b1;
      if (lines[i] && !below[i]) index = IW'(i);
    end
    single = (|lines) && !many;
  end
endmodule

// File: rtl/kp_encoder.sv
module kp_encoder #(
  parameter int ROWS   = 4,
  parameter int COLS   = 3,
  parameter int CODE_W = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              hit,
  input  logic [RW-1:0]     row_idx,
  input  logic [CW-1:0]     col_idx,
  output logic [CODE_W-1:0] code
);
  import kp_pkg::*;

  logic [CODE_W-1:0] table_q [ROWS*COLS];

  genvar gr, gc;
  generate
    for (gr = 0; gr < ROWS; gr++) begin : g_row
      for (gc = 0; gc < COLS; gc++) begin : g_col
        assign table_q[gr*COLS+gc] = CODE_W'(kp_map(gr, gc, ROWS, COLS));
      end
    end
  endgenerate

  always_comb begin
    code = CODE_W'(KP_IDLE);
    if (hit) begin
      for (int k = 0; k < ROWS*COLS; k++) begin
        if (int'(row_idx) * COLS + int'(col_idx) == k) code = table_q[k];
      end
    end
  end
endmodule

// File: rtl/kp_out_stage.sv
module kp_out_stage #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [CODE_W-1:0] d_code,
  output logic [CODE_W-1:0] q_code,
  output logic              q_valid,
  output logic              q_new
);
  import kp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_code  <= CODE_W'(KP_IDLE);
      q_valid <= 1'b0;
      q_new   <= 1'b0;
    end else begin
      q_code  <= d_valid ? d_code : CODE_W'(KP_IDLE);
      q_valid <= d_valid;
      q_new   <= d_valid && (!q_valid || (d_code != q_code));
    end
  end
endmodule

// File: rtl/keypad_code_conv.sv
module keypad_code_conv #(
  parameter int ROWS   = 4,
  parameter int COLS   = 3,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROWS-1:0]   row_in,
  input  logic [COLS-1:0]   col_in,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid,
  output logic              key_new
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic          row_one, col_one, hit;
  logic [RW-1:0] row_idx;
  logic [CW-1:0] col_idx;
  logic [CODE_W-1:0] comb_code;

  kp_line_check #(.W(ROWS)) u_rows (
    .lines(row_in), .single(row_one), .index(row_idx)
  );

  kp_line_check #(.W(COLS)) u_cols (
    .lines(col_in), .single(col_one), .index(col_idx)
  );

  assign hit = row_one && col_one;

  kp_encoder #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) u_enc (
    .hit(hit), .row_idx(row_idx), .col_idx(col_idx), .code(comb_code)
  );

  kp_out_stage #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .d_valid(hit), .d_code(comb_code),
    .q_code(key_code), .q_valid(key_valid), .q_new(key_new)
  );
endmodule

// File: rtl/keypad_code_conv_chk.sv
module keypad_code_conv_chk #(
  parameter int ROWS   = 4,
  parameter int COLS   = 3,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ROWS-1:0]   row_in,
  input logic [COLS-1:0]   col_in,
  input logic [CODE_W-1:0] key_code,
  input logic              key_valid,
  input logic              key_new
);
  // R4 / R5 / R6: an invalid output always carries the idle code
  a_r4_idle_code: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> key_code == {CODE_W{1'b1}});

  // R5: several rows or columns lead to no key on the next cycle
  a_r5_multi_line: assert property (@(posedge clk) disable iff (rst)
    ($countones(row_in) > 1 || $countones(col_in) > 1) |=> !key_valid);

  // R6: lines of only one kind lead to no key
  a_r6_half_press: assert property (@(posedge clk) disable iff (rst)
    ((row_in == '0) != (col_in == '0)) |=> !key_valid);

  // R8: reset clears the outputs
  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (key_code == {CODE_W{1'b1}} && !key_valid && !key_new));

  // R9: the pulse accompanies a rising valid and only appears with valid
  a_r9_rise_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(key_valid) |-> key_new);
  a_r9_pulse_valid: assert property (@(posedge clk) disable iff (rst)
    key_new |-> key_valid);

  // R10: a held key gives no further pulse
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (key_valid && $past(key_valid) && $stable(key_code)) |-> !key_new);
endmodule

bind keypad_code_conv keypad_code_conv_chk #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .row_in(row_in), .col_in(col_in),
  .key_code(key_code), .key_valid(key_valid), .key_new(key_new)
);

// File: tb/test_keypad_code_conv.sv
`timescale 1ns/1ps
module test_keypad_code_conv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_in = '0;
  logic [2:0] col_in = '0;
  logic [3:0] key_code;
  logic       key_valid, key_new;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  string tag   = "R8";

  logic [3:0] m_code  = 4'hF;
  logic       m_valid = 1'b0;
  logic       m_new   = 1'b0;

  always #2.5 clk = ~clk;

  keypad_code_conv i_keypad_code_conv (
    .clk(clk), .rst(rst), .row_in(row_in), .col_in(col_in),
    .key_code(key_code), .key_valid(key_valid), .key_new(key_new)
  );

  // Reference: idle unless exactly one row and one column are high
  function automatic int ref_code(input logic [3:0] r, input logic [2:0] c);
    int nr = 0, nc = 0, ri = 0, ci = 0;
    for (int i = 0; i < 4; i++) if (r[i]) begin nr++; ri = i + 1; end
    for (int i = 0; i < 3; i++) if (c[i]) begin nc++; ci = i + 1; end
    if (nr != 1 || nc != 1) return -1;
    if (ri <= 3) return 3 * (ri - 1) + ci;   // R1
    case (ci)
      1: return 10;                          // R3 star
      2: return 0;                           // R2 zero
      default: return 11;                    // R3 hash
    endcase
  endfunction

  always @(posedge clk) begin
    int k;
    k = ref_code(row_in, col_in);
    if (rst) begin
      m_code <= 4'hF; m_valid <= 1'b0; m_new <= 1'b0;
    end else begin
      m_code  <= (k < 0) ? 4'hF : 4'(k);
      m_valid <= (k >= 0);
      m_new   <= (k >= 0) && (!m_valid || 4'(k) != m_code);
    end
  end

  task automatic check_now();
    n_checks++;
    if (key_code !== m_code) begin
      n_fail++;
      $display("FAIL %s code: actual %b expected %b", tag, key_code, m_code);
    end
    n_checks++;
    if (key_valid !== m_valid) begin
      n_fail++;
      $display("FAIL %s valid: actual %b expected %b", tag, key_valid, m_valid);
    end
    n_checks++;
    if (key_new !== m_new) begin
      n_fail++;
      $display("FAIL %s new: actual %b expected %b", tag, key_new, m_new);
    end
  endtask

  // Check the result of the previous stimulus, then apply the next one
  task automatic step(input logic r_st, input logic [3:0] r, input logic [2:0] c,
                      input string t);
    @(negedge clk);
    check_now();
    rst = r_st; row_in = r; col_in = c; tag = t;
  endtask

  initial begin
    step(1'b1, 4'b0000, 3'b000, "R8");
    step(1'b1, 4'b0000, 3'b000, "R8");
    step(1'b0, 4'b0000, 3'b000, "R4");
    step(1'b0, 4'b0000, 3'b000, "R4");
    // every key, separated by idle, each giving a fresh pulse (R9)
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 3; c++) begin
        string t;
        t = (r < 3) ? "R1_R9" : ((c == 1) ? "R2_R9" : "R3_R9");
        step(1'b0, 4'(1 << r), 3'(1 << c), t);
        step(1'b0, 4'b0000, 3'b000, "R4_R7");
      end
    end
    // held key: a single pulse then silence (R10)
    for (int i = 0; i < 4; i++) step(1'b0, 4'b0010, 3'b010, "R10_hold");
    // direct change between keys while valid stays high (R10)
    step(1'b0, 4'b0001, 3'b001, "R10_change");
    step(1'b0, 4'b1000, 3'b100, "R10_change");
    step(1'b0, 4'b1000, 3'b100, "R10_hold");
    // several lines high (R5)
    step(1'b0, 4'b0011, 3'b001, "R5_rows");
    step(1'b0, 4'b0100, 3'b110, "R5_cols");
    step(1'b0, 4'b1111, 3'b111, "R5_all");
    step(1'b0, 4'b0100, 3'b010, "R9_after_multi");
    // half presses (R6)
    step(1'b0, 4'b0100, 3'b000, "R6_row_only");
    step(1'b0, 4'b0000, 3'b100, "R6_col_only");
    // reset while a key is held (R8)
    step(1'b0, 4'b0001, 3'b010, "R1");
    step(1'b1, 4'b0001, 3'b010, "R8");
    step(1'b0, 4'b0001, 3'b010, "R9_after_reset");
    step(1'b0, 4'b0000, 3'b000, "R4");
    step(1'b0, 4'b0000, 3'b000, "R4");
    @(negedge clk);
    check_now();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule